// File: doc/BRIEF.md
# Synchronous SRAM Data Path with Selectable Read Latency

This block holds the storage and data side of a synchronous SRAM that shares one data bus for reads and writes. Each clock edge it captures one access from the address sequencer: a select flag, a word address, the write controls and the write data. A write is committed to the internal word array on that same edge, under a byte mask formed from a global-write input and per-lane byte enables. A word is four 8-bit lanes plus one parity bit per lane.

Read data leaves the block either through an output register (pipelined mode) or straight from the array (flow-through mode). The choice is made by a static mode input. The block also computes the enable for the external bus drivers. A deselect, write or ignored command captured at an edge turns that enable off at once, one stage ahead of the read data pipeline. An asynchronous active-low output-enable gates the drivers off. A registered sleep input puts the block into standby: commands are ignored and the stored data is kept.

Top module: `sync_sram_datapath`

## Requirements
- R1: A selected cycle with `globalWrN` low writes all four lanes, parity bits included, whatever `byteWrN` and `laneWrN` are. The drivers stay off in the cycle that follows.
- R2: A selected cycle with `globalWrN` high and `byteWrN` low writes only the lanes whose `laneWrN` bit is low. Lane i is data bits 8i+7..8i together with parity bit 32+i of the 36-bit word. All other lanes of the word keep their old contents.
- R3: A selected cycle with `globalWrN` high is a read when `byteWrN` is high or when `laneWrN` is all ones. Such a cycle leaves the array unchanged and drives all lanes.
- R4: In flow-through mode (`pipeMode` low), a read captured at edge n puts the addressed word on `rdData` with `driveEn` high, starting right after edge n.
- R5: In pipelined mode (`pipeMode` high), a read captured at edge n puts its word on `rdData` after edge n+1. `driveEn` is high in that cycle only if the command captured at edge n+1 is also a read.
- R6: A deselect or write captured at an edge forces `driveEn` low for the following cycle in both modes, even when pipelined read data is pending.
- R7: `outEnN` high drives `driveEn` low at once, with no clock edge. `outEnN` low raises `driveEn` only in a cycle that carries read data.
- R8: A read taken while `outEnN` is high (a dummy read) still enters the read pipeline. In pipelined mode its word is shown in the next cycle if that cycle is a read with `outEnN` low.
- R9: A command captured while `sleepReq` is high is ignored: no write reaches the array and `driveEn` stays low. The array contents are retained across sleep.
- R10: While reset is asserted, and right after it, `driveEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| accSel | input | 1 | Access present this cycle (low = deselect) |
| accAddr | input | ADDR_W | Word address from the sequencer |
| globalWrN | input | 1 | Write every lane, active low |
| byteWrN | input | 1 | Byte-write qualifier, active low |
| laneWrN | input | LANES | Per-lane write enables, active low |
| wrData | input | 9*LANES | Write word: data bytes low, parity bits on top |
| pipeMode | input | 1 | 1 = pipelined read, 0 = flow-through read |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleepReq | input | 1 | Standby request, active high, sampled at the clock |
| rdData | output | 9*LANES | Read word |
| driveEn | output | 1 | Enable for the external data drivers |

## Verification
Writes are due on the capturing edge, so a read of the same address at the next edge returns the new word. Flow-through read data and driver-off effects from deselect, write and sleep appear right after the edge that captures the command. Pipelined read data appears one edge later. The output-enable gate acts within the cycle, with no edge. The bench drives each vector after a falling edge, samples 2 ns after the following rising edge, and compares against the result due at that edge. It also toggles `outEnN` between edges to check that the gate does not wait for the clock.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

  // Strobes from the control section to the data section
  typedef struct packed {
    logic wrEn;      // commit masked write this edge
    logic loadAddr;  // capture address this edge
    logic loadOut;   // load output register this edge
    logic selPipe;   // present registered word on rdData
  } dpStrobe_t;

endpackage

// File: rtl/ssram_wr_decode.sv
module ssram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             globalWrN,
  input  logic             byteWrN,
  input  logic [LANES-1:0] laneWrN,
  output logic [LANES-1:0] laneMask,
  output logic             isWrite
);

  always_comb begin
    if (!globalWrN)    laneMask = '1;
    else if (!byteWrN) laneMask = ~laneWrN;
    else               laneMask = '0;
    isWrite = |laneMask;
  end

endmodule

// File: rtl/ssram_ctrl.sv
module ssram_ctrl
  import ssram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accSel,
  input  logic             globalWrN,
  input  logic             byteWrN,
  input  logic [LANES-1:0] laneWrN,
  input  logic             pipeMode,
  input  logic             outEnN,
  input  logic             sleepReq,
  output dpStrobe_t        strobe,
  output logic [LANES-1:0] laneMask,
  output logic             driveEn
);

  logic isWrite;
  logic accept;
  logic rdNow;
  logic rdStage1;   // read captured at the most recent edge
  logic rdStage2;   // read captured one edge earlier
  logic sleepQ;
  logic baseDrive;

  ssram_wr_decode #(.LANES(LANES)) u_dec (
    .globalWrN (globalWrN),
    .byteWrN   (byteWrN),
    .laneWrN   (laneWrN),
    .laneMask  (laneMask),
    .isWrite   (isWrite)
  );

  assign accept = accSel & ~sleepReq;
  assign rdNow  = accept & ~isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdStage1 <= 1'b0;
      rdStage2 <= 1'b0;
      sleepQ   <= 1'b0;
    end else begin
      rdStage1 <= rdNow;
      rdStage2 <= rdStage1;
      sleepQ   <= sleepReq;
    end
  end

  always_comb begin
    strobe.wrEn     = accept & isWrite;
    strobe.loadAddr = accept;
    strobe.loadOut  = rdStage1;
    strobe.selPipe  = pipeMode;
  end

  // Deselect acts from the first stage; read data needs one stage more in pipelined mode
  assign baseDrive = pipeMode ? (rdStage2 & rdStage1) : rdStage1;
  assign driveEn   = baseDrive & ~sleepQ & ~outEnN;

endmodule

// File: rtl/ssram_dpath.sv
module ssram_dpath
  import ssram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [LANES-1:0]   laneMask,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [9*LANES-1:0] wrData,
  output logic [9*LANES-1:0] rdData
);

  localparam int DATA_W = 8 * LANES;
  localparam int WORD_W = 9 * LANES;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] outQ;
  logic [WORD_W-1:0] arrWord;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int i = 0; i < LANES; i++) begin
        if (laneMask[i]) begin
          mem[accAddr][8*i +: 8]   <= wrData[8*i +: 8];
          mem[accAddr][DATA_W + i] <= wrData[DATA_W + i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      outQ  <= '0;
    end else begin
      if (strobe.loadAddr) addrQ <= accAddr;
      if (strobe.loadOut)  outQ  <= arrWord;
    end
  end

  assign arrWord = mem[addrQ];
  assign rdData  = strobe.selPipe ? outQ : arrWord;

endmodule

// File: rtl/sync_sram_datapath.sv
module sync_sram_datapath
  import ssram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int WORD_W = 9 * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accSel,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              globalWrN,
  input  logic              byteWrN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic [WORD_W-1:0] wrData,
  input  logic              pipeMode,
  input  logic              outEnN,
  input  logic              sleepReq,
  output logic [WORD_W-1:0] rdData,
  output logic              driveEn
);

  dpStrobe_t        strobe;
  logic [LANES-1:0] laneMask;

  ssram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .accSel    (accSel),
    .globalWrN (globalWrN),
    .byteWrN   (byteWrN),
    .laneWrN   (laneWrN),
    .pipeMode  (pipeMode),
    .outEnN    (outEnN),
    .sleepReq  (sleepReq),
    .strobe    (strobe),
    .laneMask  (laneMask),
    .driveEn   (driveEn)
  );

  ssram_dpath #(.LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .laneMask (laneMask),
    .accAddr  (accAddr),
    .wrData   (wrData),
    .rdData   (rdData)
  );

endmodule

// File: rtl/ssram_dp_chk.sv
module ssram_dp_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             accSel,
  input logic             globalWrN,
  input logic             byteWrN,
  input logic [LANES-1:0] laneWrN,
  input logic             pipeMode,
  input logic             outEnN,
  input logic             sleepReq,
  input logic             driveEn
);

  logic wrCmd;
  logic rdCmd;
  assign wrCmd = accSel && !sleepReq && (!globalWrN || (!byteWrN && !(&laneWrN)));
  assign rdCmd = accSel && !sleepReq && !wrCmd;

  // R6: a captured write silences the drivers in the next cycle
  p_wr_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd |=> !driveEn);

  // R6: a captured deselect silences the drivers in the next cycle
  p_desel_r6: assert property (@(posedge clk) disable iff (!rstN)
    !accSel |=> !driveEn);

  // R7: output enable high always gates the drivers off
  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !driveEn);

  // R9: a command captured during sleep never drives
  p_sleep_r9: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> !driveEn);

  // R4: flow-through read drives right after its capturing edge
  p_flow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && rdCmd) |=> (pipeMode || outEnN || driveEn));

endmodule

bind sync_sram_datapath ssram_dp_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_sync_sram_datapath.sv
module sim_sync_sram_datapath;

  localparam int CLK_P = 10;
  localparam int NVEC  = 24;

  typedef struct packed {
    logic        sel;
    logic        gwN;
    logic        bwN;
    logic [3:0]  lanesN;
    logic [3:0]  addr;
    logic [35:0] wd;
    logic        pipe;
    logic        oeN;
    logic        slp;
    logic        expDrv;
    logic        chk;
    logic [35:0] expD;
    logic [7:0]  req;
  } vec_t;

  // sel gwN bwN lanesN addr wd pipe oeN slp expDrv chk expD req
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b0,1'b1,4'hF,4'd1,36'hA_11223344,1'b0,1'b0,1'b0,1'b0,1'b0,36'h0,8'd1},           // 0 R1 global write
    '{1'b1,1'b1,1'b1,4'hF,4'd1,36'h0,1'b0,1'b0,1'b0,1'b1,1'b1,36'hA_11223344,8'd1},          // 1 R1 read back
    '{1'b1,1'b1,1'b0,4'b1010,4'd1,36'h9_FFEEDDCC,1'b0,1'b0,1'b0,1'b0,1'b0,36'h0,8'd2},      // 2 R2 lanes 0,2
    '{1'b1,1'b1,1'b1,4'hF,4'd1,36'h0,1'b0,1'b0,1'b0,1'b1,1'b1,36'hB_11EE33CC,8'd2},          // 3 R2 merged word
    '{1'b1,1'b1,1'b0,4'hF,4'd1,36'h0,1'b0,1'b0,1'b0,1'b1,1'b1,36'hB_11EE33CC,8'd3},          // 4 R3 no lane picked
    '{1'b1,1'b1,1'b1,4'h0,4'd1,36'h0,1'b0,1'b0,1'b0,1'b1,1'b1,36'hB_11EE33CC,8'd3},          // 5 R3 byteWrN high
    '{1'b0,1'b1,1'b1,4'hF,4'd1,36'h0,1'b0,1'b0,1'b0,1'b0,1'b0,36'h0,8'd6},                   // 6 R6 deselect
    '{1'b1,1'b1,1'b1,4'hF,4'd1,36'h0,1'b0,1'b1,1'b0,1'b0,1'b0,36'h0,8'd7},                   // 7 R7 oe high
    '{1'b1,1'b0,1'b1,4'hF,4'd2,36'h5_0A0B0C0D,1'b0,1'b0,1'b0,1'b0,1'b0,36'h0,8'd1},         // 8 R1 write addr2
    '{1'b1,1'b1,1'b1,4'hF,4'd2,36'h0,1'b0,1'b0,1'b0,1'b1,1'b1,36'h5_0A0B0C0D,8'd4},          // 9 R4 flow read
    '{1'b0,1'b1,1'b1,4'hF,4'd0,36'h0,1'b1,1'b0,1'b0,1'b0,1'b0,36'h0,8'd6},                   // 10 R6 deselect, pipe
    '{1'b1,1'b1,1'b1,4'hF,4'd1,36'h0,1'b1,1'b0,1'b0,1'b0,1'b0,36'h0,8'd5},                   // 11 R5 first read, no data yet
    '{1'b1,1'b1,1'b1,4'hF,4'd2,36'h0,1'b1,1'b0,1'b0,1'b1,1'b1,36'hB_11EE33CC,8'd5},          // 12 R5 shows addr1
    '{1'b0,1'b1,1'b1,4'hF,4'd0,36'h0,1'b1,1'b0,1'b0,1'b0,1'b0,36'h0,8'd6},                   // 13 R6 deselect cuts data
    '{1'b1,1'b1,1'b1,4'hF,4'd1,36'h0,1'b1,1'b0,1'b0,1'b0,1'b0,36'h0,8'd5},                   // 14 R5 read after deselect
    '{1'b1,1'b0,1'b1,4'hF,4'd3,36'h3_DEADBEEF,1'b1,1'b0,1'b0,1'b0,1'b0,36'h0,8'd6},         // 15 R6 write cuts data
    '{1'b1,1'b1,1'b1,4'hF,4'd3,36'h0,1'b1,1'b1,1'b0,1'b0,1'b0,36'h0,8'd8},                   // 16 R8 dummy read
    '{1'b1,1'b1,1'b1,4'hF,4'd1,36'h0,1'b1,1'b0,1'b0,1'b1,1'b1,36'h3_DEADBEEF,8'd8},          // 17 R8 dummy data out
    '{1'b1,1'b1,1'b1,4'hF,4'd2,36'h0,1'b1,1'b0,1'b0,1'b1,1'b1,36'hB_11EE33CC,8'd5},          // 18 R5 streaming
    '{1'b1,1'b0,1'b1,4'hF,4'd1,36'h0,1'b1,1'b0,1'b1,1'b0,1'b0,36'h0,8'd9},                   // 19 R9 write in sleep
    '{1'b1,1'b1,1'b1,4'hF,4'd2,36'h0,1'b1,1'b0,1'b1,1'b0,1'b0,36'h0,8'd9},                   // 20 R9 read in sleep
    '{1'b1,1'b1,1'b1,4'hF,4'd1,36'h0,1'b1,1'b0,1'b0,1'b0,1'b0,36'h0,8'd9},                   // 21 R9 wake
    '{1'b1,1'b1,1'b1,4'hF,4'd1,36'h0,1'b1,1'b0,1'b0,1'b1,1'b1,36'hB_11EE33CC,8'd9},          // 22 R9 data retained
    '{1'b0,1'b1,1'b1,4'hF,4'd0,36'h0,1'b1,1'b0,1'b0,1'b0,1'b0,36'h0,8'd6}                    // 23 R6 idle
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accSel = 1'b0;
  logic [3:0]  accAddr = '0;
  logic        globalWrN = 1'b1;
  logic        byteWrN = 1'b1;
  logic [3:0]  laneWrN = '1;
  logic [35:0] wrData = '0;
  logic        pipeMode = 1'b0;
  logic        outEnN = 1'b0;
  logic        sleepReq = 1'b0;
  logic [35:0] rdData;
  logic        driveEn;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_sram_datapath u0 (
    .clk(clk), .rstN(rstN), .accSel(accSel), .accAddr(accAddr),
    .globalWrN(globalWrN), .byteWrN(byteWrN), .laneWrN(laneWrN),
    .wrData(wrData), .pipeMode(pipeMode), .outEnN(outEnN),
    .sleepReq(sleepReq), .rdData(rdData), .driveEn(driveEn)
  );

  task automatic check(input logic ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(driveEn == 1'b0, "R10 drive in reset", {35'h0, driveEn}, 36'h0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk);
    #2;
    check(driveEn == 1'b0, "R10 drive after reset", {35'h0, driveEn}, 36'h0);

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      accSel    = VEC[k].sel;
      globalWrN = VEC[k].gwN;
      byteWrN   = VEC[k].bwN;
      laneWrN   = VEC[k].lanesN;
      accAddr   = VEC[k].addr;
      wrData    = VEC[k].wd;
      pipeMode  = VEC[k].pipe;
      outEnN    = VEC[k].oeN;
      sleepReq  = VEC[k].slp;
      @(posedge clk);
      #2;
      check(driveEn == VEC[k].expDrv, $sformatf("R%0d vec %0d driveEn", VEC[k].req, k),
            {35'h0, driveEn}, {35'h0, VEC[k].expDrv});
      if (VEC[k].chk)
        check(rdData == VEC[k].expD, $sformatf("R%0d vec %0d rdData", VEC[k].req, k),
              rdData, VEC[k].expD);
    end

    // R7 directed: output enable acts between clock edges
    @(negedge clk);
    accSel = 1'b1; globalWrN = 1'b1; byteWrN = 1'b1; laneWrN = '1;
    accAddr = 4'd2; pipeMode = 1'b1; outEnN = 1'b0; sleepReq = 1'b0;
    @(posedge clk);
    @(negedge clk);
    accAddr = 4'd3;
    @(posedge clk);
    #2;
    check(driveEn == 1'b1 && rdData == 36'h5_0A0B0C0D, "R7 read before gate", rdData, 36'h5_0A0B0C0D);
    outEnN = 1'b1;
    #1;
    check(driveEn == 1'b0, "R7 oe high mid-cycle", {35'h0, driveEn}, 36'h0);
    outEnN = 1'b0;
    #1;
    check(driveEn == 1'b1, "R7 oe low mid-cycle", {35'h0, driveEn}, 36'h1);

    // R6 directed: deselect ends the stream
    @(negedge clk);
    accSel = 1'b0;
    @(posedge clk);
    #2;
    check(driveEn == 1'b0, "R6 final deselect", {35'h0, driveEn}, 36'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule